// File: doc/BRIEF.md
# Narrow-Result Partition Allocator with Two-Phase Retag Broadcast

This block keeps track of which quarter-partitions of a physical register file are free, and it moves results that turn out narrow so that less storage stays reserved. At dispatch a destination always receives a whole register, with every partition reserved. When the producing operation completes, it reports how many partitions its value really needs. The allocator then searches the other registers for a free aligned group of exactly that size. If it finds one, the value is moved into that group and its original register is returned to the pool in full. If it finds none, the value stays where it is and only the partitions it does not use are returned.

Every completion is announced in two steps. One cycle after the completion, a first broadcast carries only the original register number, so that waiting consumers know the value is coming. One cycle after that, a narrow result also produces a second broadcast. It carries the original register number (which consumers match on) together with the register and the partition mask where the value now lives. Consumers store that pair and use it for their operand reads. A separate release port returns a register/mask pair at commit, and it reports any attempt to free a partition that is already free.

Top module: `pr_part_alloc`

## Requirements
- R1: After reset every partition of every register is free, and bc1_valid, bc2_valid and dbl_free are low.
- R2: disp_gnt is high in the same cycle as disp_req only when some register has all partitions free, and disp_reg is then the lowest-numbered such register.
- R3: A granted register has none of its partitions free in the following cycles, so a later dispatch receives a different register until the granted one is freed again.
- R4: done_size encodes the needed partition count minus one (0 = one partition, 3 = all four). One cycle after done_valid, bc1_valid is high with bc1_reg equal to done_reg.
- R5: A one-partition or two-partition result moves to the lowest-numbered register other than its own that is partly used (neither fully free nor fully used) and holds a free aligned group of that size. Pair groups are tried as mask 0011 and then 1100. Single groups are tried from bit 0 to bit 3.
- R6: After a move, the original register becomes entirely free. Two cycles after done_valid, bc2_valid is high with bc2_old_reg equal to the original register, and bc2_new_reg and bc2_mask giving the new location.
- R7: A narrow result with no suitable group elsewhere keeps its register. Its partitions above the needed count are freed, and the second broadcast then carries bc2_old_reg equal to bc2_new_reg, with bc2_mask made of the low needed-count bits.
- R8: A full-width result (done_size 3) changes no free state and produces no second broadcast.
- R9: A three-partition result is never moved. It keeps mask 0111 and frees only partition 3.
- R10: rel_valid frees the partitions in rel_mask of rel_reg. If any of them was already free, dbl_free is high for exactly the next cycle.
- R11: Partitions freed by a release become available for dispatch only from the next cycle onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_req | input | 1 | Dispatch wants a destination register |
| disp_gnt | output | 1 | Combinational grant of a full register |
| disp_reg | output | $clog2(NUM_REGS) | Granted register |
| done_valid | input | 1 | A result completes this cycle |
| done_reg | input | $clog2(NUM_REGS) | Register granted to the completing result |
| done_size | input | 2 | Needed partitions minus one |
| rel_valid | input | 1 | Commit-time release |
| rel_reg | input | $clog2(NUM_REGS) | Register to release |
| rel_mask | input | 4 | Partitions to release |
| bc1_valid | output | 1 | First broadcast valid |
| bc1_reg | output | $clog2(NUM_REGS) | Original tag of first broadcast |
| bc2_valid | output | 1 | Second broadcast valid |
| bc2_old_reg | output | $clog2(NUM_REGS) | Original tag consumers match on |
| bc2_new_reg | output | $clog2(NUM_REGS) | Register now holding the value |
| bc2_mask | output | 4 | Partitions now holding the value |
| dbl_free | output | 1 | Release touched an already-free partition |

## Verification
The bench builds the allocator with NUM_REGS set to 4 rather than the default 16. With only four registers the pool runs dry within a few dispatches, so refused grants, moves into the last partly used register and narrow results that find no group all occur often in random traffic. Directed sequences cover each group priority, the three-partition case, a repeated release and a release that coincides with a dispatch on an exhausted pool.

// File: rtl/pr_pkg.sv
`timescale 1ns/1ps
package pr_pkg;
    // partitions per physical register; group search assumes a power of two
    localparam int PARTS = 4;
    localparam int SZW   = $clog2(PARTS);

    typedef logic [PARTS-1:0] pmask_t;

    // mask of the low (sz+1) partitions
    function automatic pmask_t low_parts(input logic [SZW-1:0] sz);
        pmask_t m;
        m = '0;
        for (int i = 0; i < PARTS; i++) begin
            if (i <= int'(sz)) m[i] = 1'b1;
        end
        return m;
    endfunction

    // first aligned free group of 'need' partitions, lowest position first;
    // zero when the size has no group shape or nothing fits
    function automatic pmask_t fit_group(input pmask_t fr, input int need);
        pmask_t res;
        pmask_t g;
        logic   got;
        res = '0;
        got = 1'b0;
        if (need > 0 && need < PARTS && (need & (need - 1)) == 0) begin
            for (int b = 0; b < PARTS; b++) begin
                g = pmask_t'(((1 << need) - 1) << b);
                if (!got && (b % need) == 0 && (b + need) <= PARTS && (fr & g) == g) begin
                    res = g;
                    got = 1'b1;
                end
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/pr_group_find.sv
`timescale 1ns/1ps
module pr_group_find
    import pr_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  pmask_t [NUM_REGS-1:0]         free_map,
    input  logic [$clog2(NUM_REGS)-1:0]   skip_reg,
    input  logic [SZW:0]                  need,
    output logic                          hit,
    output logic [$clog2(NUM_REGS)-1:0]   hit_reg,
    output pmask_t                        hit_mask
);
    localparam int RW = $clog2(NUM_REGS);

    pmask_t [NUM_REGS-1:0] cand;
    logic   [NUM_REGS-1:0] ok;

    // per-register candidate group
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_comb begin
            cand[r] = fit_group(free_map[r], int'(need));
            ok[r]   = (cand[r] != '0) && (free_map[r] != '1) && (skip_reg != RW'(r));
        end
    end

    // lowest register wins
    always_comb begin
        hit      = 1'b0;
        hit_reg  = '0;
        hit_mask = '0;
        for (int r = NUM_REGS - 1; r >= 0; r--) begin
            if (ok[r]) begin
                hit      = 1'b1;
                hit_reg  = RW'(r);
                hit_mask = cand[r];
            end
        end
    end
endmodule

// File: rtl/pr_full_pick.sv
`timescale 1ns/1ps
module pr_full_pick
    import pr_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  pmask_t [NUM_REGS-1:0]       free_map,
    output logic                        found,
    output logic [$clog2(NUM_REGS)-1:0] idx
);
    localparam int RW = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0] whole;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_whole
        assign whole[r] = (free_map[r] == '1);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int r = NUM_REGS - 1; r >= 0; r--) begin
            if (whole[r]) begin
                found = 1'b1;
                idx   = RW'(r);
            end
        end
    end
endmodule

// File: rtl/pr_part_alloc.sv
`timescale 1ns/1ps
module pr_part_alloc
    import pr_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        disp_req,
    output logic                        disp_gnt,
    output logic [$clog2(NUM_REGS)-1:0] disp_reg,
    input  logic                        done_valid,
    input  logic [$clog2(NUM_REGS)-1:0] done_reg,
    input  logic [SZW-1:0]              done_size,
    input  logic                        rel_valid,
    input  logic [$clog2(NUM_REGS)-1:0] rel_reg,
    input  logic [PARTS-1:0]            rel_mask,
    output logic                        bc1_valid,
    output logic [$clog2(NUM_REGS)-1:0] bc1_reg,
    output logic                        bc2_valid,
    output logic [$clog2(NUM_REGS)-1:0] bc2_old_reg,
    output logic [$clog2(NUM_REGS)-1:0] bc2_new_reg,
    output logic [PARTS-1:0]            bc2_mask,
    output logic                        dbl_free
);
    localparam int RW = $clog2(NUM_REGS);

    typedef struct packed {
        pmask_t [NUM_REGS-1:0] free;
        logic                  bc1_v;
        logic [RW-1:0]         bc1_reg;
        logic                  pend_v;
        logic [RW-1:0]         pend_old;
        logic [RW-1:0]         pend_new;
        pmask_t                pend_mask;
        logic                  bc2_v;
        logic [RW-1:0]         bc2_old;
        logic [RW-1:0]         bc2_new;
        pmask_t                bc2_mask;
        logic                  dbl;
    } state_t;

    state_t st_q, st_d;

    pmask_t [NUM_REGS-1:0] free_map;
    assign free_map = st_q.free;

    logic          full_found;
    logic [RW-1:0] full_idx;
    logic          grp_hit;
    logic [RW-1:0] grp_reg;
    pmask_t        grp_mask;
    logic [SZW:0]  need;

    assign need = {1'b0, done_size} + (SZW+1)'(1);

    pr_full_pick #(.NUM_REGS(NUM_REGS)) u_pick (
        .free_map (st_q.free),
        .found    (full_found),
        .idx      (full_idx)
    );

    pr_group_find #(.NUM_REGS(NUM_REGS)) u_find (
        .free_map (st_q.free),
        .skip_reg (done_reg),
        .need     (need),
        .hit      (grp_hit),
        .hit_reg  (grp_reg),
        .hit_mask (grp_mask)
    );

    assign disp_gnt = disp_req & full_found;
    assign disp_reg = full_idx;

    always_comb begin
        pmask_t used;
        st_d        = st_q;
        used        = low_parts(done_size);
        // broadcast pipeline: pending second phase goes out now
        st_d.bc1_v    = 1'b0;
        st_d.bc2_v    = st_q.pend_v;
        st_d.bc2_old  = st_q.pend_old;
        st_d.bc2_new  = st_q.pend_new;
        st_d.bc2_mask = st_q.pend_mask;
        st_d.pend_v   = 1'b0;
        st_d.dbl      = 1'b0;

        // dispatch claims a whole register
        if (disp_gnt) begin
            st_d.free[full_idx] = '0;
        end

        // completion: first phase now, decide the home of the value
        if (done_valid) begin
            st_d.bc1_v   = 1'b1;
            st_d.bc1_reg = done_reg;
            if (done_size != '1) begin
                st_d.pend_v   = 1'b1;
                st_d.pend_old = done_reg;
                if (grp_hit) begin
                    st_d.free[grp_reg]  = st_d.free[grp_reg] & ~grp_mask;
                    st_d.free[done_reg] = '1;
                    st_d.pend_new       = grp_reg;
                    st_d.pend_mask      = grp_mask;
                end else begin
                    st_d.free[done_reg] = st_d.free[done_reg] | ~used;
                    st_d.pend_new       = done_reg;
                    st_d.pend_mask      = used;
                end
            end
        end

        // commit release, after everything else this cycle
        if (rel_valid) begin
            st_d.dbl = |(rel_mask & (st_q.free[rel_reg] | st_d.free[rel_reg]));
            st_d.free[rel_reg] = st_d.free[rel_reg] | rel_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.free <= {NUM_REGS{{PARTS{1'b1}}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign bc1_valid   = st_q.bc1_v;
    assign bc1_reg     = st_q.bc1_reg;
    assign bc2_valid   = st_q.bc2_v;
    assign bc2_old_reg = st_q.bc2_old;
    assign bc2_new_reg = st_q.bc2_new;
    assign bc2_mask    = st_q.bc2_mask;
    assign dbl_free    = st_q.dbl;
endmodule

// File: rtl/pr_part_alloc_chk.sv
`timescale 1ns/1ps
module pr_part_alloc_chk
    import pr_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        disp_req,
    input logic                        disp_gnt,
    input logic [$clog2(NUM_REGS)-1:0] disp_reg,
    input logic                        rel_valid,
    input logic                        bc1_valid,
    input logic [$clog2(NUM_REGS)-1:0] bc1_reg,
    input logic                        bc2_valid,
    input logic [$clog2(NUM_REGS)-1:0] bc2_old_reg,
    input logic [$clog2(NUM_REGS)-1:0] bc2_new_reg,
    input logic [PARTS-1:0]            bc2_mask,
    input logic                        dbl_free,
    input pmask_t [NUM_REGS-1:0]       free_map
);
    // R2: grant only on request, only of a fully free register
    a_r2_grant_from_free_reg: assert property (@(posedge clk) disable iff (!rst_n)
        disp_gnt |-> (disp_req && free_map[disp_reg] == '1));

    // R3: a granted register is fully in use afterwards
    a_r3_grant_claims_all: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_gnt && !rel_valid) |=> (free_map[$past(disp_reg)] == '0));

    // R6: second phase follows the first phase for the same original tag
    a_r6_bc2_follows_bc1: assert property (@(posedge clk) disable iff (!rst_n)
        bc2_valid |-> ($past(bc1_valid) && bc2_old_reg == $past(bc1_reg)));

    // R8: second phase never announces a full-width or empty location
    a_r8_bc2_mask_partial: assert property (@(posedge clk) disable iff (!rst_n)
        bc2_valid |-> (bc2_mask != '1 && bc2_mask != '0));

    // R5: a moved value occupies one or two partitions
    a_r5_move_group_size: assert property (@(posedge clk) disable iff (!rst_n)
        (bc2_valid && bc2_old_reg != bc2_new_reg) |->
        ($countones(bc2_mask) == 1 || $countones(bc2_mask) == 2));

    // R7: a kept value announces a mask of contiguous low partitions
    a_r7_keep_low_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bc2_valid && bc2_old_reg == bc2_new_reg) |->
        ((bc2_mask & (bc2_mask + 1'b1)) == '0));

    // R10: the error flag only follows a release
    a_r10_dbl_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_free |-> $past(rel_valid));
endmodule

bind pr_part_alloc pr_part_alloc_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_req    (disp_req),
    .disp_gnt    (disp_gnt),
    .disp_reg    (disp_reg),
    .rel_valid   (rel_valid),
    .bc1_valid   (bc1_valid),
    .bc1_reg     (bc1_reg),
    .bc2_valid   (bc2_valid),
    .bc2_old_reg (bc2_old_reg),
    .bc2_new_reg (bc2_new_reg),
    .bc2_mask    (bc2_mask),
    .dbl_free    (dbl_free),
    .free_map    (free_map)
);

// File: tb/pr_part_alloc_tb_top.sv
`timescale 1ns/1ps
module pr_part_alloc_tb_top;
    localparam int NR = 4;
    localparam int RW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_req = 1'b0;
    logic          disp_gnt;
    logic [RW-1:0] disp_reg;
    logic          done_valid = 1'b0;
    logic [RW-1:0] done_reg = '0;
    logic [1:0]    done_size = '0;
    logic          rel_valid = 1'b0;
    logic [RW-1:0] rel_reg = '0;
    logic [3:0]    rel_mask = '0;
    logic          bc1_valid;
    logic [RW-1:0] bc1_reg;
    logic          bc2_valid;
    logic [RW-1:0] bc2_old_reg, bc2_new_reg;
    logic [3:0]    bc2_mask;
    logic          dbl_free;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    pr_part_alloc #(.NUM_REGS(NR)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_req(disp_req), .disp_gnt(disp_gnt), .disp_reg(disp_reg),
        .done_valid(done_valid), .done_reg(done_reg), .done_size(done_size),
        .rel_valid(rel_valid), .rel_reg(rel_reg), .rel_mask(rel_mask),
        .bc1_valid(bc1_valid), .bc1_reg(bc1_reg),
        .bc2_valid(bc2_valid), .bc2_old_reg(bc2_old_reg), .bc2_new_reg(bc2_new_reg),
        .bc2_mask(bc2_mask), .dbl_free(dbl_free)
    );

    // reference state
    bit [3:0] mf[NR];
    int q_infl[$];
    int q_lreg[$];
    int q_lmask[$];
    bit e_bc1_v, e_pend_v, e_bc2_v, e_dbl;
    int e_bc1_reg, e_po, e_pn, e_pm, e_bo, e_bn, e_bm;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_regs();
        chk(bc1_valid == e_bc1_v, "R4 bc1_valid", int'(bc1_valid), int'(e_bc1_v));
        if (e_bc1_v) chk(int'(bc1_reg) == e_bc1_reg, "R4 bc1_reg", int'(bc1_reg), e_bc1_reg);
        chk(bc2_valid == e_bc2_v, "R6 bc2_valid", int'(bc2_valid), int'(e_bc2_v));
        if (e_bc2_v) begin
            chk(int'(bc2_old_reg) == e_bo, "R6 bc2_old_reg", int'(bc2_old_reg), e_bo);
            chk(int'(bc2_new_reg) == e_bn, "R5 bc2_new_reg", int'(bc2_new_reg), e_bn);
            chk(int'(bc2_mask) == e_bm, "R5 bc2_mask", int'(bc2_mask), e_bm);
        end
        chk(dbl_free == e_dbl, "R10 dbl_free", int'(dbl_free), int'(e_dbl));
    endtask

    // one cycle: check registered outputs, drive, check grant, advance model
    task automatic step(input bit dq, input bit dv, input int dr, input int ds,
                        input bit rv, input int rr, input int rm, input string tg);
        bit [3:0] nf[NR];
        bit egnt, hit;
        int ereg, need, used, hr, hm, res_r, res_m;
        chk_regs();
        disp_req   = dq;
        done_valid = dv;
        done_reg   = RW'(dr);
        done_size  = 2'(ds);
        rel_valid  = rv;
        rel_reg    = RW'(rr);
        rel_mask   = 4'(rm);
        #1;
        egnt = 1'b0;
        ereg = 0;
        if (dq) for (int r = NR - 1; r >= 0; r--) if (mf[r] == 4'hF) begin egnt = 1'b1; ereg = r; end
        chk(disp_gnt == egnt, {tg, " disp_gnt"}, int'(disp_gnt), int'(egnt));
        if (egnt) chk(int'(disp_reg) == ereg, {tg, " disp_reg"}, int'(disp_reg), ereg);

        nf = mf;
        if (egnt) nf[ereg] = 4'h0;
        e_bc2_v = e_pend_v; e_bo = e_po; e_bn = e_pn; e_bm = e_pm;
        e_pend_v = 1'b0;
        e_bc1_v = dv;
        e_bc1_reg = dr;
        res_r = dr;
        res_m = 15;
        if (dv && ds != 3) begin
            need = ds + 1;
            used = (1 << need) - 1;
            hit = 1'b0; hr = 0; hm = 0;
            if (need <= 2) begin
                for (int r = 0; r < NR; r++) begin
                    if (!hit && r != dr && mf[r] != 4'hF && mf[r] != 4'h0) begin
                        for (int b = 0; b < 4; b += need) begin
                            int g;
                            g = ((1 << need) - 1) << b;
                            if (!hit && (int'(mf[r]) & g) == g) begin hit = 1'b1; hr = r; hm = g; end
                        end
                    end
                end
            end
            e_pend_v = 1'b1;
            e_po = dr;
            if (hit) begin
                nf[hr] = nf[hr] & ~4'(hm);
                nf[dr] = 4'hF;
                e_pn = hr; e_pm = hm;
                res_r = hr; res_m = hm;
            end else begin
                nf[dr] = nf[dr] | ~4'(used);
                e_pn = dr; e_pm = used;
                res_m = used;
            end
        end
        e_dbl = rv && ((4'(rm) & (mf[rr] | nf[rr])) != 0);
        if (rv) nf[rr] = nf[rr] | 4'(rm);
        mf = nf;
        if (egnt) q_infl.push_back(ereg);
        if (dv) begin q_lreg.push_back(res_r); q_lmask.push_back(res_m); end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        disp_req = 1'b0; done_valid = 1'b0; rel_valid = 1'b0;
        for (int r = 0; r < NR; r++) mf[r] = 4'hF;
        q_infl.delete(); q_lreg.delete(); q_lmask.delete();
        e_bc1_v = 0; e_pend_v = 0; e_bc2_v = 0; e_dbl = 0;
        e_bc1_reg = 0; e_po = 0; e_pn = 0; e_pm = 0; e_bo = 0; e_bn = 0; e_bm = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1 watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R1: idle after reset
        chk(bc1_valid == 1'b0, "R1 bc1_valid", int'(bc1_valid), 0);
        chk(bc2_valid == 1'b0, "R1 bc2_valid", int'(bc2_valid), 0);
        chk(dbl_free == 1'b0, "R1 dbl_free", int'(dbl_free), 0);

        step(1, 0, 0, 0, 0, 0, 0, "R2");        // P0
        step(1, 0, 0, 0, 0, 0, 0, "R3");        // P1
        step(0, 1, 0, 1, 0, 0, 0, "R7");        // P0 needs two, nothing partly used
        step(0, 0, 0, 0, 0, 0, 0, "R7");
        chk(bc2_valid && bc2_old_reg == 0 && bc2_new_reg == 0, "R7 kept", int'(bc2_new_reg), 0);
        chk(bc2_mask == 4'b0011, "R7 low mask", int'(bc2_mask), 3);
        step(0, 1, 1, 1, 0, 0, 0, "R5");        // P1 needs two -> P0 upper pair
        step(0, 0, 0, 0, 0, 0, 0, "R6");
        chk(bc2_valid && bc2_old_reg == 1 && bc2_new_reg == 0, "R6 moved", int'(bc2_new_reg), 0);
        chk(bc2_mask == 4'b1100, "R5 upper pair", int'(bc2_mask), 12);
        step(1, 0, 0, 0, 0, 0, 0, "R6");        // released P1 granted again
        step(0, 1, 1, 3, 0, 0, 0, "R8");        // full width
        step(0, 0, 0, 0, 0, 0, 0, "R8");
        chk(bc2_valid == 1'b0, "R8 no second phase", int'(bc2_valid), 0);
        step(1, 0, 0, 0, 0, 0, 0, "R2");        // P2
        step(0, 1, 2, 2, 0, 0, 0, "R9");        // three parts
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        chk(bc2_new_reg == 2 && bc2_mask == 4'b0111, "R9 kept 0111", int'(bc2_mask), 7);
        step(1, 0, 0, 0, 0, 0, 0, "R2");        // P3
        step(0, 1, 3, 0, 0, 0, 0, "R5");        // single -> P2 bit 3
        step(0, 0, 0, 0, 0, 0, 0, "R5");
        chk(bc2_old_reg == 3 && bc2_new_reg == 2 && bc2_mask == 4'b1000, "R5 single", int'(bc2_mask), 8);
        step(0, 0, 0, 0, 1, 0, 3, "R10");
        step(0, 0, 0, 0, 1, 0, 3, "R10");       // same partitions again
        chk(dbl_free == 1'b1, "R10 double free", int'(dbl_free), 1);
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        chk(dbl_free == 1'b0, "R10 one cycle", int'(dbl_free), 0);

        do_reset();
        for (int i = 0; i < NR; i++) step(1, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 1, 0, 15, "R11");      // pool empty, release lands at the edge
        step(1, 0, 0, 0, 0, 0, 0, "R11");       // now P0 is granted

        do_reset();
        for (int i = 0; i < 3000; i++) begin
            bit dq, dv, rv;
            int dr, ds, rr, rm, k;
            dq = ($urandom % 3) != 0;
            dv = 0; dr = 0; ds = 0; rv = 0; rr = 0; rm = 0;
            if (q_infl.size() > 0 && ($urandom % 2) == 0) begin
                k = $urandom % q_infl.size();
                dr = q_infl[k]; q_infl.delete(k);
                dv = 1; ds = $urandom % 4;
            end
            if (q_lreg.size() > 0 && ($urandom % 3) == 0) begin
                k = $urandom % q_lreg.size();
                rr = q_lreg[k]; rm = q_lmask[k];
                q_lreg.delete(k); q_lmask.delete(k);
                rv = 1;
            end
            step(dq, dv, dr, ds, rv, rr, rm, "R3");
        end
        step(0, 0, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, 0, "R6");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule